// File: doc/BRIEF.md
# Transaction Conflict Event Monitor

This block sits beside one processor's transactional cache and captures the facts needed to explain why speculative work was thrown away. While a transaction runs, it keeps a small read set. For each distinct object address that the transaction loads, the set holds the address and the program counter of the first load of that address. A free-running per-transaction cycle counter measures how much work has been done since the transaction began or last restarted.

When another thread's commit invalidates an address held in the read set, the block files one conflict record and marks it valid. The record holds the object address, the writer's thread ID, the PC of the first read and the cycles wasted. A second record type covers speculative buffer overflow. When the overflow starts, the block latches the PC and an overflow kind. The overflowed transaction then runs serialized while it holds the commit token. When that transaction commits, the block files the PC, the kind and the number of cycles the token was held.

Software polls the two records through plain output ports and pulses a read strobe to release each one. All counting, totals and reports happen in software. If a record is still unread when a new event of the same type arrives, the hardware keeps the older record and raises a loss flag.

Top module: `txn_conflict_mon`

## Requirements
- R1: After reset, the conflict record and the overflow record are both invalid, their loss flags are 0, and every record field reads zero.
- R2: The read set stores the PC of the first transactional load of an address. Later loads of the same address in the same transaction do not replace that PC.
- R3: A violation whose address is in the current read set files a conflict record on the next clock edge. The record holds the violation address, the writer thread ID, the stored first-read PC and the wasted-cycle count, and conf_valid goes to 1.
- R4: The wasted-cycle count is the number of cycles from the cycle in which tx_begin or tx_restart was sampled up to, but not including, the cycle in which the violation is sampled. Both strobes restart this count.
- R5: A violation is ignored in three cases: its address is not in the read set, no transaction is active, or tx_begin or tx_restart is sampled in the same cycle.
- R6: After a conflict is filed, the transaction is inactive and its read set is empty. Further violations are ignored until the next tx_begin or tx_restart.
- R7: An overflow start during an active transaction latches its PC and its 2-bit kind. At the next tx_commit, the block files an overflow record holding that PC, that kind and a duration. The duration is the number of cycles from the start cycle up to, but not including, the commit cycle. A commit with no overflow in progress files nothing.
- R8: A tx_begin or tx_restart during an overflow cancels it, and no overflow record is filed.
- R9: If an event of either type arrives while that type's record is still valid, the stored record is kept unchanged and its loss flag is set.
- R10: rd_conf (or rd_spill) clears that record's valid and loss flags on the next edge. If a new event of the same type arrives in the same cycle, the new event is filed, the record stays valid and the loss flag is 0.
- R11: The read set holds NOBJ distinct addresses. Once it is full, loads of further new addresses are not tracked, and violations on those addresses are ignored.
- R12: The wasted-cycle counter and the overflow duration counter saturate at all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_begin | input | 1 | Transaction begins |
| tx_restart | input | 1 | Transaction restarts after an abort |
| tx_commit | input | 1 | Transaction commits |
| ld_valid | input | 1 | A transactional load is performed |
| ld_pc | input | PW | PC of the load |
| ld_addr | input | AW | Object address of the load |
| viol_valid | input | 1 | A remote commit wrote an address |
| viol_addr | input | AW | Address written by the remote commit |
| viol_tid | input | TW | Thread ID of the committing writer |
| spill_start | input | 1 | Speculative buffer overflow begins |
| spill_pc | input | PW | PC at which the overflow occurred |
| spill_kind | input | 2 | Overflow kind: 0 set capacity, 1 LRU eviction, 2 victim full, 3 other |
| rd_conf | input | 1 | Software releases the conflict record |
| rd_spill | input | 1 | Software releases the overflow record |
| conf_valid | output | 1 | Conflict record holds unread data |
| conf_lost | output | 1 | A conflict was dropped while the record was full |
| conf_addr | output | AW | Conflicting object address |
| conf_tid | output | TW | Writer thread ID |
| conf_pc | output | PW | PC of the first read of the object |
| conf_cycles | output | CW | Wasted cycles |
| spill_valid | output | 1 | Overflow record holds unread data |
| spill_lost | output | 1 | An overflow was dropped while the record was full |
| spill_pc_o | output | PW | PC of the overflow |
| spill_kind_o | output | 2 | Kind of the overflow |
| spill_dur | output | CW | Cycles spent serialized |

## Verification
Every record output comes from a register. An event sampled on one clock edge is therefore visible at the ports from the following falling edge, and a read strobe takes effect on that same edge. The scoreboard tags each expected record with the cycle number one past the cycle in which its stimulus is driven. It compares the ports only on the falling edge of that cycle. Expected wasted-cycle counts and durations are differences of the bench's own cycle numbers, taken when the strobes were driven.

// File: rtl/txm_pkg.sv
package txm_pkg;
    typedef enum logic [1:0] {
        SPILL_SETCAP = 2'd0,
        SPILL_LRU    = 2'd1,
        SPILL_VICTIM = 2'd2,
        SPILL_OTHER  = 2'd3
    } spill_kind_e;
endpackage

// File: rtl/txm_satcnt.sv
// Saturating cycle counter: loads 1 on start, steps while run is high.
module txm_satcnt #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic         run,
    output logic [W-1:0] cnt
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (start)
            cnt_d = W'(1);
        else if (run && (cnt_q != '1))
            cnt_d = cnt_q + W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign cnt = cnt_q;
endmodule

// File: rtl/txm_readset.sv
// Small associative set of first-read (address, PC) pairs for one transaction.
module txm_readset #(
    parameter int NOBJ = 4,
    parameter int AW   = 32,
    parameter int PW   = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          ld_en,
    input  logic [AW-1:0] ld_addr,
    input  logic [PW-1:0] ld_pc,
    input  logic [AW-1:0] probe_addr,
    output logic          probe_hit,
    output logic [PW-1:0] probe_pc
);
    typedef struct packed {
        logic [NOBJ-1:0]         used;
        logic [NOBJ-1:0][AW-1:0] addr;
        logic [NOBJ-1:0][PW-1:0] pc;
    } rs_t;

    rs_t rs_d, rs_q;
    logic seen, placed;
    logic [NOBJ-1:0] hit_vec;

    always_comb begin
        rs_d   = rs_q;
        seen   = 1'b0;
        placed = 1'b0;
        if (clr)
            rs_d.used = '0;
        for (int i = 0; i < NOBJ; i++) begin
            if (rs_d.used[i] && (rs_d.addr[i] == ld_addr))
                seen = 1'b1;
        end
        if (ld_en && !seen) begin
            for (int i = 0; i < NOBJ; i++) begin
                if (!placed && !rs_d.used[i]) begin
                    placed        = 1'b1;
                    rs_d.used[i]  = 1'b1;
                    rs_d.addr[i]  = ld_addr;
                    rs_d.pc[i]    = ld_pc;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rs_q <= '0;
        else        rs_q <= rs_d;
    end

    for (genvar g = 0; g < NOBJ; g++) begin : g_match
        assign hit_vec[g] = rs_q.used[g] && (rs_q.addr[g] == probe_addr);
    end

    always_comb begin
        probe_pc = '0;
        for (int i = 0; i < NOBJ; i++) begin
            if (hit_vec[i])
                probe_pc = probe_pc | rs_q.pc[i];
        end
    end

    assign probe_hit = |hit_vec;
endmodule

// File: rtl/txm_evslot.sv
// One-deep record holder: keeps the oldest unread record, flags later losses.
module txm_evslot #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cap,
    input  logic [W-1:0] cap_data,
    input  logic         ack,
    output logic         valid,
    output logic         lost,
    output logic [W-1:0] data
);
    typedef struct packed {
        logic         v;
        logic         l;
        logic [W-1:0] dat;
    } slot_t;

    slot_t sl_d, sl_q;

    always_comb begin
        sl_d = sl_q;
        if (ack) begin
            sl_d.v = 1'b0;
            sl_d.l = 1'b0;
        end
        if (cap) begin
            if (sl_d.v) begin
                sl_d.l = 1'b1;
            end else begin
                sl_d.v   = 1'b1;
                sl_d.dat = cap_data;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sl_q <= '0;
        else        sl_q <= sl_d;
    end

    assign valid = sl_q.v;
    assign lost  = sl_q.l;
    assign data  = sl_q.dat;
endmodule

// File: rtl/txn_conflict_mon.sv
module txn_conflict_mon
    import txm_pkg::*;
#(
    parameter int AW   = 32,
    parameter int PW   = 32,
    parameter int TW   = 3,
    parameter int CW   = 24,
    parameter int NOBJ = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tx_begin,
    input  logic          tx_restart,
    input  logic          tx_commit,
    input  logic          ld_valid,
    input  logic [PW-1:0] ld_pc,
    input  logic [AW-1:0] ld_addr,
    input  logic          viol_valid,
    input  logic [AW-1:0] viol_addr,
    input  logic [TW-1:0] viol_tid,
    input  logic          spill_start,
    input  logic [PW-1:0] spill_pc,
    input  logic [1:0]    spill_kind,
    input  logic          rd_conf,
    input  logic          rd_spill,
    output logic          conf_valid,
    output logic          conf_lost,
    output logic [AW-1:0] conf_addr,
    output logic [TW-1:0] conf_tid,
    output logic [PW-1:0] conf_pc,
    output logic [CW-1:0] conf_cycles,
    output logic          spill_valid,
    output logic          spill_lost,
    output logic [PW-1:0] spill_pc_o,
    output logic [1:0]    spill_kind_o,
    output logic [CW-1:0] spill_dur
);
    localparam int CREC_W = AW + TW + PW + CW;
    localparam int SREC_W = PW + 2 + CW;

    typedef struct packed {
        logic          active;
        logic          busy;
        logic [PW-1:0] spc;
        spill_kind_e   skind;
    } st_t;

    st_t st_d, st_q;

    logic          fresh;
    logic          probe_hit;
    logic [PW-1:0] probe_pc;
    logic          conf_cap;
    logic          spill_go;
    logic          spill_cap;
    logic          txn_active;
    logic [CW-1:0] cyc_cnt;
    logic [CW-1:0] spill_cnt;
    logic [CREC_W-1:0] conf_rec;
    logic [SREC_W-1:0] spill_rec;

    assign fresh      = tx_begin | tx_restart;
    assign txn_active = st_q.active;
    assign conf_cap   = viol_valid && st_q.active && probe_hit && !fresh;
    assign spill_go   = spill_start && st_q.active && !st_q.busy && !fresh && !tx_commit;
    assign spill_cap  = st_q.busy && tx_commit && !fresh;

    always_comb begin
        st_d = st_q;
        if (fresh) begin
            st_d.active = 1'b1;
            st_d.busy   = 1'b0;
        end else begin
            if (tx_commit || conf_cap) begin
                st_d.active = 1'b0;
                st_d.busy   = 1'b0;
            end
            if (spill_go) begin
                st_d.busy  = 1'b1;
                st_d.spc   = spill_pc;
                st_d.skind = spill_kind_e'(spill_kind);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    txm_readset #(.NOBJ(NOBJ), .AW(AW), .PW(PW)) u_rset (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr        (fresh | tx_commit | conf_cap),
        .ld_en      (ld_valid && (fresh || (st_q.active && !tx_commit && !conf_cap))),
        .ld_addr    (ld_addr),
        .ld_pc      (ld_pc),
        .probe_addr (viol_addr),
        .probe_hit  (probe_hit),
        .probe_pc   (probe_pc)
    );

    txm_satcnt #(.W(CW)) u_txcyc (
        .clk   (clk),
        .rst_n (rst_n),
        .start (fresh),
        .run   (st_q.active && !conf_cap && !tx_commit),
        .cnt   (cyc_cnt)
    );

    txm_satcnt #(.W(CW)) u_spcyc (
        .clk   (clk),
        .rst_n (rst_n),
        .start (spill_go),
        .run   (st_q.busy && !tx_commit),
        .cnt   (spill_cnt)
    );

    txm_evslot #(.W(CREC_W)) u_conf_slot (
        .clk      (clk),
        .rst_n    (rst_n),
        .cap      (conf_cap),
        .cap_data ({viol_addr, viol_tid, probe_pc, cyc_cnt}),
        .ack      (rd_conf),
        .valid    (conf_valid),
        .lost     (conf_lost),
        .data     (conf_rec)
    );

    txm_evslot #(.W(SREC_W)) u_spill_slot (
        .clk      (clk),
        .rst_n    (rst_n),
        .cap      (spill_cap),
        .cap_data ({st_q.spc, st_q.skind, spill_cnt}),
        .ack      (rd_spill),
        .valid    (spill_valid),
        .lost     (spill_lost),
        .data     (spill_rec)
    );

    assign {conf_addr, conf_tid, conf_pc, conf_cycles} = conf_rec;
    assign {spill_pc_o, spill_kind_o, spill_dur}       = spill_rec;
endmodule

// File: rtl/txm_checker.sv
module txm_checker #(
    parameter int AW = 32,
    parameter int CW = 24
) (
    input logic          clk,
    input logic          rst_n,
    input logic          tx_begin,
    input logic          tx_restart,
    input logic          rd_conf,
    input logic          conf_valid,
    input logic          conf_lost,
    input logic [AW-1:0] conf_addr,
    input logic          conf_cap,
    input logic          spill_cap,
    input logic          spill_valid,
    input logic [CW-1:0] spill_dur,
    input logic [CW-1:0] spill_cnt,
    input logic [CW-1:0] cyc_cnt,
    input logic          txn_active
);
    p_capture_sets_valid_r3: assert property (@(posedge clk) disable iff (!rst_n)
        conf_cap |=> conf_valid);

    p_count_restart_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_begin || tx_restart) |=> (cyc_cnt == CW'(1)));

    p_no_capture_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !txn_active |-> !conf_cap);

    p_capture_ends_txn_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (conf_cap && !tx_begin && !tx_restart) |=> !txn_active);

    p_spill_record_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (spill_cap && !spill_valid) |=> (spill_valid && (spill_dur == $past(spill_cnt))));

    p_keep_oldest_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (conf_cap && conf_valid && !rd_conf) |=> (conf_lost && $stable(conf_addr)));

    p_read_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_conf && !conf_cap) |=> (!conf_valid && !conf_lost));

    p_valid_holds_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (conf_valid && !rd_conf) |=> conf_valid);

    p_saturate_r12: assert property (@(posedge clk) disable iff (!rst_n)
        ((cyc_cnt == '1) && !tx_begin && !tx_restart) |=> (cyc_cnt == '1));
endmodule

bind txn_conflict_mon txm_checker #(.AW(AW), .CW(CW)) u_chk (.*);

// File: tb/tb_txn_conflict_mon.sv
module tb_txn_conflict_mon;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 16;
    localparam int PW = 16;
    localparam int TW = 3;
    localparam int CW = 8;
    localparam int NOBJ = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tx_begin = 0, tx_restart = 0, tx_commit = 0;
    logic ld_valid = 0;
    logic [PW-1:0] ld_pc = '0;
    logic [AW-1:0] ld_addr = '0;
    logic viol_valid = 0;
    logic [AW-1:0] viol_addr = '0;
    logic [TW-1:0] viol_tid = '0;
    logic spill_start = 0;
    logic [PW-1:0] spill_pc = '0;
    logic [1:0] spill_kind = '0;
    logic rd_conf = 0, rd_spill = 0;
    logic conf_valid, conf_lost;
    logic [AW-1:0] conf_addr;
    logic [TW-1:0] conf_tid;
    logic [PW-1:0] conf_pc;
    logic [CW-1:0] conf_cycles;
    logic spill_valid, spill_lost;
    logic [PW-1:0] spill_pc_o;
    logic [1:0] spill_kind_o;
    logic [CW-1:0] spill_dur;

    always #(CLK_PERIOD/2) clk = ~clk;

    txn_conflict_mon #(.AW(AW), .PW(PW), .TW(TW), .CW(CW), .NOBJ(NOBJ)) dut (.*);

    typedef struct {
        int          due;
        bit          sp;
        bit          full;
        bit          v;
        bit          l;
        logic [15:0] a;
        logic [2:0]  t;
        logic [15:0] p;
        logic [7:0]  c;
        string       tag;
    } item_t;

    item_t exp_q[$];
    item_t it;
    int cyc = 0;
    int nvec = 0;
    int nfail = 0;
    int cb = 0;
    int sb = 0;
    int wsave = 0;
    bit done = 0;

    always @(posedge clk) cyc <= cyc + 1;

    // Monitor: compares the ports against each expectation in its due cycle.
    always @(negedge clk) begin
        while (exp_q.size() > 0 && exp_q[0].due == cyc) begin
            it = exp_q.pop_front();
            nvec++;
            if (!it.sp) begin
                if (conf_valid !== it.v || conf_lost !== it.l ||
                    ((it.v || it.full) && (conf_addr !== it.a || conf_tid !== it.t ||
                                           conf_pc !== it.p || conf_cycles !== it.c))) begin
                    nfail++;
                    $display("FAIL %s conflict: actual v=%0d l=%0d a=%h t=%0d pc=%h cyc=%0d expected v=%0d l=%0d a=%h t=%0d pc=%h cyc=%0d",
                             it.tag, conf_valid, conf_lost, conf_addr, conf_tid, conf_pc, conf_cycles,
                             it.v, it.l, it.a, it.t, it.p, it.c);
                end
            end else begin
                if (spill_valid !== it.v || spill_lost !== it.l ||
                    ((it.v || it.full) && (spill_pc_o !== it.p || spill_kind_o !== it.t[1:0] ||
                                           spill_dur !== it.c))) begin
                    nfail++;
                    $display("FAIL %s overflow: actual v=%0d l=%0d pc=%h kind=%0d dur=%0d expected v=%0d l=%0d pc=%h kind=%0d dur=%0d",
                             it.tag, spill_valid, spill_lost, spill_pc_o, spill_kind_o, spill_dur,
                             it.v, it.l, it.p, it.t[1:0], it.c);
                end
            end
        end
    end

    function automatic void expc(bit v, bit l, logic [15:0] a, logic [2:0] t,
                                 logic [15:0] p, int c, string tag, bit full = 0);
        item_t x;
        x.due = cyc + 1; x.sp = 0; x.full = full; x.v = v; x.l = l;
        x.a = a; x.t = t; x.p = p; x.c = 8'(c); x.tag = tag;
        exp_q.push_back(x);
    endfunction

    function automatic void exps(bit v, bit l, logic [15:0] p, logic [1:0] k,
                                 int d, string tag, bit full = 0);
        item_t x;
        x.due = cyc + 1; x.sp = 1; x.full = full; x.v = v; x.l = l;
        x.a = '0; x.t = {1'b0, k}; x.p = p; x.c = 8'(d); x.tag = tag;
        exp_q.push_back(x);
    endfunction

    task automatic step();
        @(negedge clk);
        tx_begin = 0; tx_restart = 0; tx_commit = 0; ld_valid = 0;
        viol_valid = 0; spill_start = 0; rd_conf = 0; rd_spill = 0;
    endtask

    task automatic idle(int n);
        repeat (n) step();
    endtask

    task automatic t_begin();   cb = cyc; tx_begin = 1;   step(); endtask
    task automatic t_restart(); cb = cyc; tx_restart = 1; step(); endtask
    task automatic t_commit();  tx_commit = 1; step(); endtask
    task automatic t_rdc();     rd_conf = 1; step(); endtask
    task automatic t_rds();     rd_spill = 1; step(); endtask

    task automatic t_load(logic [15:0] pc, logic [15:0] a);
        ld_valid = 1; ld_pc = pc; ld_addr = a; step();
    endtask

    task automatic t_viol(logic [15:0] a, logic [2:0] tid);
        viol_valid = 1; viol_addr = a; viol_tid = tid; step();
    endtask

    task automatic t_spill(logic [15:0] pc, logic [1:0] k);
        sb = cyc; spill_start = 1; spill_pc = pc; spill_kind = k; step();
    endtask

    task automatic report();
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            nfail++;
            $display("FAIL watchdog: actual run still busy, expected completion");
            report();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1: reset state, all fields zero
        expc(0, 0, 16'h0, 0, 16'h0, 0, "R1", 1);
        exps(0, 0, 16'h0, 0, 0, "R1", 1);
        step();

        // R2, R3: first-read PC kept, record fields
        t_begin();
        t_load(16'h01A0, 16'h0040);
        t_load(16'h01B0, 16'h0040);
        t_load(16'h01C0, 16'h0088);
        idle(4);
        expc(1, 0, 16'h0040, 3, 16'h01A0, cyc - cb, "R2 R3");
        t_viol(16'h0040, 3);
        expc(0, 0, 0, 0, 0, 0, "R10");
        t_rdc();
        // R6: transaction is dead after a conflict
        expc(0, 0, 0, 0, 0, 0, "R6");
        t_viol(16'h0088, 2);

        // R4: restart resets the cycle count
        t_restart();
        t_load(16'h02A0, 16'h0100);
        idle(2);
        expc(1, 0, 16'h0100, 5, 16'h02A0, cyc - cb, "R4");
        t_viol(16'h0100, 5);
        t_rdc();

        // R5: unread address, then inactive transaction
        t_begin();
        t_load(16'h03A0, 16'h0200);
        expc(0, 0, 0, 0, 0, 0, "R5");
        t_viol(16'h0204, 1);
        t_commit();
        expc(0, 0, 0, 0, 0, 0, "R5");
        t_viol(16'h0200, 1);

        // R9: second conflict while first unread
        t_begin();
        t_load(16'h04A0, 16'h0300);
        idle(1);
        wsave = cyc - cb;
        expc(1, 0, 16'h0300, 4, 16'h04A0, wsave, "R3");
        t_viol(16'h0300, 4);
        t_restart();
        t_load(16'h04B0, 16'h0300);
        expc(1, 1, 16'h0300, 4, 16'h04A0, wsave, "R9");
        t_viol(16'h0300, 6);
        expc(0, 0, 0, 0, 0, 0, "R10");
        t_rdc();

        // R10: read and new conflict in the same cycle
        t_begin();
        t_load(16'h05A0, 16'h0400);
        expc(1, 0, 16'h0400, 1, 16'h05A0, cyc - cb, "R3");
        t_viol(16'h0400, 1);
        t_restart();
        t_load(16'h05B0, 16'h0404);
        expc(1, 0, 16'h0404, 2, 16'h05B0, cyc - cb, "R10");
        viol_valid = 1; viol_addr = 16'h0404; viol_tid = 2; rd_conf = 1;
        step();
        t_rdc();

        // R11: read set capacity
        t_begin();
        for (int i = 0; i < NOBJ + 1; i++)
            t_load(16'h0600 + 16'(i), 16'h0500 + 16'(i));
        expc(0, 0, 0, 0, 0, 0, "R11");
        t_viol(16'h0500 + 16'(NOBJ), 1);
        expc(1, 0, 16'h0500 + 16'(NOBJ - 1), 1, 16'h0600 + 16'(NOBJ - 1), cyc - cb, "R11");
        t_viol(16'h0500 + 16'(NOBJ - 1), 1);
        t_rdc();

        // R7: overflow record at commit
        t_begin();
        idle(1);
        t_spill(16'h07A0, 2'd1);
        idle(3);
        exps(1, 0, 16'h07A0, 2'd1, cyc - sb, "R7");
        t_commit();
        exps(0, 0, 0, 0, 0, "R10");
        t_rds();
        t_begin();
        exps(0, 0, 0, 0, 0, "R7");
        t_commit();

        // R8: restart cancels overflow
        t_begin();
        t_spill(16'h08A0, 2'd2);
        idle(2);
        t_restart();
        idle(1);
        exps(0, 0, 0, 0, 0, "R8");
        t_commit();

        // R9: overflow record kept when unread
        t_begin();
        t_spill(16'h09A0, 2'd3);
        idle(1);
        wsave = cyc - sb;
        exps(1, 0, 16'h09A0, 2'd3, wsave, "R7");
        t_commit();
        t_begin();
        t_spill(16'h09B0, 2'd0);
        exps(1, 1, 16'h09A0, 2'd3, wsave, "R9");
        t_commit();
        exps(0, 0, 0, 0, 0, "R10");
        t_rds();

        // R12: wasted-cycle counter saturates
        t_begin();
        t_load(16'h0AA0, 16'h0A00);
        idle(300);
        expc(1, 0, 16'h0A00, 7, 16'h0AA0, 255, "R12");
        t_viol(16'h0A00, 7);
        t_rdc();

        idle(2);
        done = 1;
        report();
    end
endmodule